// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block produces the active-low system reset of a synchronous subsystem. It watches a supply-good logic level from an external voltage comparator. While that level says the supply is too low, reset is held. Once the supply is good again, a stabilization count, scaled from a 100 ms target, must finish before reset is released. A dip in the supply during operation asserts reset again at once. The release after such a dip follows the same count as the first power-up.

Besides supply events, three other sources can request reset: an external reset pin (active low, asynchronous), a watchdog request and a software request. Each source holds reset for at least a minimum number of cycles. A small read-only register records which kind of event caused the last reset. Bit 1 of this register is the power-on flag. A supply event sets it, and any other cause clears it. A monitor-enable input switches supply supervision on or off. The supply-good level and the reset pin each pass through a two-flop synchronizer before the block uses them. The block itself is cleared by an asynchronous power-on reset, `arst_n`.

Top module: `supply_reset_seq`

## Requirements
- R1: With `mon_en`=1 and `supply_ok`=0, `sys_rst_n` stays 0. This holds both while `arst_n` is asserted and afterwards.
- R2: The count length is T = CLK_KHZ*TIMEOUT_MS cycles. With `mon_en`=1, `supply_ok` rises and stays high, and no other source is active. `sys_rst_n` is then still 0 after the T+2-th rising clock edge and becomes 1 after the T+3-th edge.
- R3: While `sys_rst_n`=1 and `mon_en`=1, a fall of `supply_ok` drives `sys_rst_n` to 0 after the third rising edge.
- R4: After a supply dip, recovery uses the same T+3 edge release timing as R2.
- R5: After a supply-caused reset, `rd_data[1]` (power-on flag) reads 1.
- R6: A pin, watchdog or software reset clears `rd_data[1]` to 0.
- R7: After a supply-caused reset only bit 1 is defined. The other bits read 0 in this design, but the only value a user may rely on is bit 1.
- R8: With `mon_en`=0, a low `supply_ok` neither asserts `sys_rst_n` nor changes `rd_data`.
- R9: If `supply_ok` drops before the count completes, the count restarts. Release then comes T+3 edges after the final rise of `supply_ok`.
- R10: A one-cycle `wdt_req` or `sw_req` holds `sys_rst_n` at 0 for exactly MIN_PULSE cycles. It is 0 after edges 1 to MIN_PULSE and 1 after edge MIN_PULSE+1. It sets `rd_data` to 4'b0100 (watchdog, bit 2) or 4'b1000 (software, bit 3).
- R11: A low level on `ext_rst_n` is synchronized, so `sys_rst_n` is 0 after the third edge. Reset lasts at least MIN_PULSE cycles after the pin is released, and `rd_data` becomes 4'b0001 (pin, bit 0).
- R12: `rd_data` shows the reset-source register when `rd_en`=1 and reads 0 when `rd_en`=0. While `sys_rst_n`=1 the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on clear of the block, active low |
| mon_en | input | 1 | Supply supervision enable, tied high in normal use |
| supply_ok | input | 1 | Comparator output, 1 when the supply is above threshold (asynchronous) |
| ext_rst_n | input | 1 | External reset pin, active low (asynchronous) |
| wdt_req | input | 1 | Watchdog reset request, synchronous |
| sw_req | input | 1 | Software reset request, synchronous |
| rd_en | input | 1 | Read enable of the status read port |
| rd_data | output | 4 | Reset-source register: bit0 pin, bit1 power-on, bit2 watchdog, bit3 software |
| sys_rst_n | output | 1 | System reset output, active low, registered |

## Verification
The bench builds the block with CLK_KHZ=1 and TIMEOUT_MS=20, which gives a 20-cycle stabilization count, and with MIN_PULSE=4. With these values the release edge can be checked exactly, and a mid-count supply glitch fits in a few dozen cycles. The short minimum pulse makes the exact reset width from watchdog and software requests observable. The same width also bounds the stretched reset from the synchronized pin in a short window.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int SRC_W   = 4;
  localparam int B_PIN   = 0;
  localparam int B_POR   = 1;
  localparam int B_WDT   = 2;
  localparam int B_SW    = 3;

  function automatic int timeout_cycles(input int khz, input int ms);
    int c;
    c = khz * ms;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic logic [SRC_W-1:0] src_code(input logic pin, input logic wdt,
                                                input logic sw);
    logic [SRC_W-1:0] v;
    v = '0;
    v[B_PIN] = pin;
    v[B_WDT] = wdt;
    v[B_SW]  = sw;
    return v;
  endfunction
endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  input  logic good,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (!good) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(CYC - 1)) done <= 1'b1;
      else                     cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int MIN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic hold
);
  localparam int PW = $clog2(MIN + 1);
  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          left <= '0;
    else if (req)         left <= PW'(MIN - 1);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign hold = req | (left != '0);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rstseq_pkg::*;
#(
  parameter int CLK_KHZ    = 50000,
  parameter int TIMEOUT_MS = 100,
  parameter int MIN_PULSE  = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             mon_en,
  input  logic             supply_ok,
  input  logic             ext_rst_n,
  input  logic             wdt_req,
  input  logic             sw_req,
  input  logic             rd_en,
  output logic [SRC_W-1:0] rd_data,
  output logic             sys_rst_n
);
  localparam int T_CYC = timeout_cycles(CLK_KHZ, TIMEOUT_MS);

  logic [1:0]       sync_q;
  logic             supply_s;
  logic             pin_s;
  logic             tmr_done;
  logic             sup_hold;
  logic             ext_any;
  logic             ext_hold;
  logic [SRC_W-1:0] ext_code;
  logic [SRC_W-1:0] rsrc;

  rstseq_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .arst_n(arst_n), .d({ext_rst_n, supply_ok}), .q(sync_q)
  );
  assign supply_s = sync_q[0];
  assign pin_s    = sync_q[1];

  rstseq_timer #(.CYC(T_CYC)) u_tmr (
    .clk(clk), .arst_n(arst_n), .en(mon_en), .good(supply_s), .done(tmr_done)
  );

  assign sup_hold = mon_en & (~supply_s | ~tmr_done);

  assign ext_code = src_code(~pin_s, wdt_req, sw_req);
  assign ext_any  = |ext_code;

  rstseq_stretch #(.MIN(MIN_PULSE)) u_str (
    .clk(clk), .arst_n(arst_n), .req(ext_any), .hold(ext_hold)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rsrc      <= '0;
      sys_rst_n <= 1'b0;
    end else begin
      sys_rst_n <= ~(sup_hold | ext_hold);
      if (sup_hold)     rsrc <= SRC_W'(1) << B_POR;
      else if (ext_any) rsrc <= ext_code;
    end
  end

  assign rd_data = rd_en ? rsrc : '0;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       mon_en,
  input logic       supply_s,
  input logic       sup_hold,
  input logic       ext_any,
  input logic [3:0] rsrc,
  input logic       sys_rst_n
);
  p_low_held_r1: assert property (@(posedge clk) disable iff (!arst_n)
    mon_en && !supply_s |=> !sys_rst_n);

  p_release_good_r2: assert property (@(posedge clk) disable iff (!arst_n)
    mon_en && $rose(sys_rst_n) |-> supply_s);

  p_drop_now_r3: assert property (@(posedge clk) disable iff (!arst_n)
    mon_en && $fell(supply_s) |=> !sys_rst_n);

  p_por_set_r5: assert property (@(posedge clk) disable iff (!arst_n)
    sup_hold |=> rsrc[1]);

  p_por_clear_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_hold && ext_any |=> !rsrc[1]);

  p_req_rst_r10: assert property (@(posedge clk) disable iff (!arst_n)
    ext_any |=> !sys_rst_n);

  p_src_hold_r12: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst_n |-> $stable(rsrc));
endmodule

bind supply_reset_seq rstseq_chk u_chk (
  .clk(clk), .arst_n(arst_n), .mon_en(mon_en), .supply_s(supply_s),
  .sup_hold(sup_hold), .ext_any(ext_any), .rsrc(rsrc), .sys_rst_n(sys_rst_n)
);

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ  = 1;
  localparam int MS   = 20;
  localparam int MINP = 4;
  localparam int T    = KHZ * MS;

  logic       clk = 1'b0;
  logic       arst_n, mon_en, supply_ok, ext_rst_n, wdt_req, sw_req, rd_en;
  logic [3:0] rd_data;
  logic       sys_rst_n;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_seq #(.CLK_KHZ(KHZ), .TIMEOUT_MS(MS), .MIN_PULSE(MINP)) i_supply_reset_seq (
    .clk(clk), .arst_n(arst_n), .mon_en(mon_en), .supply_ok(supply_ok),
    .ext_rst_n(ext_rst_n), .wdt_req(wdt_req), .sw_req(sw_req), .rd_en(rd_en),
    .rd_data(rd_data), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_powerup(input string req);
    supply_ok = 1'b1;
    edges(T + 2);
    chk(req, {3'b0, sys_rst_n}, 4'd0);
    edges(1);
    chk(req, {3'b0, sys_rst_n}, 4'd1);
    chk({req, " R5 por flag"}, {3'b0, rd_data[1]}, 4'd1);
  endtask

  task automatic t_drop;
    supply_ok = 1'b0;
    edges(3);
    chk("R3 drop asserts", {3'b0, sys_rst_n}, 4'd0);
    edges(15);
    chk("R1 held while low", {3'b0, sys_rst_n}, 4'd0);
  endtask

  task automatic t_glitch;
    supply_ok = 1'b1;
    edges(10);
    supply_ok = 1'b0;
    edges(2);
    supply_ok = 1'b1;
    edges(T + 2);
    chk("R9 restart still low", {3'b0, sys_rst_n}, 4'd0);
    edges(1);
    chk("R9 restart release", {3'b0, sys_rst_n}, 4'd1);
  endtask

  task automatic t_req(input logic is_sw, input string req, input logic [3:0] code);
    if (is_sw) sw_req = 1'b1; else wdt_req = 1'b1;
    edges(1);
    sw_req = 1'b0; wdt_req = 1'b0;
    chk({req, " asserted"}, {3'b0, sys_rst_n}, 4'd0);
    edges(MINP - 1);
    chk({req, " width low"}, {3'b0, sys_rst_n}, 4'd0);
    edges(1);
    chk({req, " width end"}, {3'b0, sys_rst_n}, 4'd1);
    chk({req, " flag"}, rd_data, code);
    chk("R6 por cleared", {3'b0, rd_data[1]}, 4'd0);
  endtask

  task automatic t_pin;
    ext_rst_n = 1'b0;
    edges(3);
    chk("R11 pin asserts", {3'b0, sys_rst_n}, 4'd0);
    ext_rst_n = 1'b1;
    edges(MINP);
    chk("R11 pin min width", {3'b0, sys_rst_n}, 4'd0);
    edges(MINP + 4);
    chk("R11 pin release", {3'b0, sys_rst_n}, 4'd1);
    chk("R11 pin flag", rd_data, 4'b0001);
  endtask

  task automatic t_read;
    logic [3:0] first;
    first = rd_data;
    rd_en = 1'b0;
    edges(1);
    chk("R12 read gated", rd_data, 4'b0000);
    rd_en = 1'b1;
    edges(20);
    chk("R12 stable while released", rd_data, first);
  endtask

  task automatic t_mon_off;
    mon_en = 1'b0;
    edges(2);
    supply_ok = 1'b0;
    edges(20);
    chk("R8 no reset when disabled", {3'b0, sys_rst_n}, 4'd1);
    chk("R8 flag untouched", rd_data, 4'b0001);
    supply_ok = 1'b1;
    edges(4);
    mon_en = 1'b1;
    edges(5);
    chk("R8 re-enable with good supply", {3'b0, sys_rst_n}, 4'd1);
  endtask

  initial begin
    arst_n = 1'b0; mon_en = 1'b1; supply_ok = 1'b0; ext_rst_n = 1'b1;
    wdt_req = 1'b0; sw_req = 1'b0; rd_en = 1'b1;
    edges(3);
    chk("R1 reset during arst", {3'b0, sys_rst_n}, 4'd0);
    arst_n = 1'b1;
    edges(30);
    chk("R1 held supply low", {3'b0, sys_rst_n}, 4'd0);
    t_powerup("R2 power-up release");
    chk("R7 por bit after power-up", {3'b0, rd_data[1]}, 4'd1);
    t_drop;
    t_powerup("R4 recovery release");
    t_glitch;
    t_req(1'b0, "R10 watchdog", 4'b0100);
    t_req(1'b1, "R10 software", 4'b1000);
    t_pin;
    t_read;
    t_mon_off;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule